// File: doc/BRIEF.md
# Addressable Serial UART

This block is a full-duplex asynchronous serial transceiver. Each direction queues words in its own first-in, first-out store, eight entries deep by default. A host pushes transmit words through a valid/ready port and pops received words through a second valid/ready port. One clock divider produces a tick at sixteen times the bit rate. The transmitter spends sixteen ticks on each bit, and the receiver oversamples the line at that tick rate.

A set of static configuration inputs selects the frame layout. An optional parity bit can be added, with even or odd sense. An optional ninth "mark" bit can also be added, so that several nodes can share one line. In that multi-drop mode, a frame carrying mark = 1 is an address. A node keeps the data frames that follow an address equal to its own, and drops everything after an address that does not match. The receiver tags every stored word with parity-error, framing-error and break flags. A receive store that is full sets a sticky overflow indication.

Top module: `uart_mp`

## Requirements
- R1: After reset, txd is 1, tx_ready is 1, rx_valid is 0 and rx_ovf is 0.
- R2: The transmitter sends its bits in this order: a start bit of 0; data bits 0 to 7, least significant bit first; the mark bit, only when cfg_mp_en = 1; the parity bit, only when cfg_par_en = 1; and a stop bit of 1. Each bit lasts 16 ticks, and one tick lasts CLK_DIV clocks. With even parity, the parity bit equals the XOR of the data bits and the transmitted mark bit. With odd parity, it is the inverse of that value.
- R3: The transmit store accepts TX_DEPTH words behind the frame currently on the line. While the line is idle, tx_valid held high is therefore accepted TX_DEPTH + 1 times before tx_ready drops.
- R4: The receiver finds the start bit by a low level and confirms it 8 ticks later, at mid-bit. It then samples each following bit 16 ticks after the previous sample, and stores data and mark in the order the frames arrived. With cfg_mp_en = 0, the stored mark is 0.
- R5: When cfg_par_en = 1, rx_perr is 1 exactly when the received parity bit disagrees with the selected sense.
- R6: A stop bit sampled as 0, in a frame that has any nonzero bit, is stored with rx_ferr = 1 and rx_brk = 0.
- R7: A frame whose bits are all 0, stop position included, is stored once as a break: data 0, rx_brk = 1, rx_ferr = 0, rx_perr = 0. Nothing more is stored until the line has returned to 1 and a new start bit arrives.
- R8: When cfg_mp_en = 1, the receiver applies address filtering. An address frame (mark = 1) equal to cfg_node_addr is stored, and the data frames (mark = 0) that follow it are stored. A non-matching address, and the data that follows it, are dropped. Data frames received after reset and before any address are dropped.
- R9: The receive store holds RX_DEPTH words. A frame that arrives while the store is full is dropped and sets rx_ovf, which stays at 1 until reset.
- R10: While rx_valid = 1 and rx_ready = 0, the head word stays unchanged. A pop happens on a clock edge where both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_par_en | input | 1 | Adds a parity bit to each frame |
| cfg_par_odd | input | 1 | Selects odd parity when set, even parity when clear |
| cfg_mp_en | input | 1 | Adds the mark bit and enables address filtering |
| cfg_node_addr | input | 8 | The address this node answers to |
| tx_data | input | 8 | Transmit data word |
| tx_mark | input | 1 | Transmit mark bit (1 marks an address) |
| tx_valid | input | 1 | A transmit word is offered |
| tx_ready | output | 1 | The transmit store has room |
| txd | output | 1 | Serial output line, idle high |
| rxd | input | 1 | Serial input line, asynchronous |
| rx_data | output | 8 | Head word data |
| rx_mark | output | 1 | Head word mark bit |
| rx_perr | output | 1 | Head word parity error |
| rx_ferr | output | 1 | Head word framing error |
| rx_brk | output | 1 | Head word is a break |
| rx_valid | output | 1 | The receive store is not empty |
| rx_ready | input | 1 | The host pops the head word |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
A transmit word first appears on txd one to two clocks after the handshake. The bench does not count that latency: it waits for the falling start edge, then samples each bit at its centre, half a bit period and then one full period later. A received word is pushed one clock after the mid-stop-bit sample, which falls about half a bit period before the stop bit ends. The stimulus tasks keep the line high for a further full bit period before any read, so every stored word is in place before it is examined. Reads and register-level checks are sampled on falling edges, and a pop is one high cycle of rx_ready across a single rising edge.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;
   localparam int DW = 8;

   typedef struct packed {
      logic          mark;
      logic [DW-1:0] data;
   } tx_word_t;

   typedef struct packed {
      logic          brk;
      logic          ferr;
      logic          perr;
      logic          mark;
      logic [DW-1:0] data;
   } rx_word_t;

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_WAITHI
   } rx_state_t;
endpackage

// File: rtl/uart_mp_tick.sv
module uart_mp_tick #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CLK_DIV == 1) begin : g_every
         logic unused_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) unused_q <= 1'b0;
            else        unused_q <= ~unused_q;
         assign tick = 1'b1 | unused_q;
      end else begin : g_div
         localparam int CW = $clog2(CLK_DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         cnt <= '0;
            else if (cnt == CW'(CLK_DIV - 1))   cnt <= '0;
            else                                cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == CW'(CLK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/uart_mp_fifo.sv
module uart_mp_fifo #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   output logic             full,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);

   generate
      if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("uart_mp_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [AW:0]      cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) if (do_push) mem[wptr] <= din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         if (do_push && !do_pop)      cnt <= cnt + 1'b1;
         else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
   import uart_mp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tick,
   input  logic     par_en,
   input  logic     par_odd,
   input  logic     mp_en,
   input  logic     q_empty,
   input  tx_word_t q_word,
   output logic     q_pop,
   output logic     txd
);
   logic        busy;
   logic [11:0] sh;
   logic [3:0]  nleft, tcnt, nb;
   logic [11:0] fr;
   logic        pbit;

   always_comb begin
      pbit     = (^q_word.data) ^ (mp_en & q_word.mark) ^ par_odd;
      fr       = '1;
      fr[0]    = 1'b0;
      fr[8:1]  = q_word.data;
      if (mp_en) begin
         fr[9] = q_word.mark;
         if (par_en) fr[10] = pbit;
      end else if (par_en) begin
         fr[9] = pbit;
      end
      nb = 4'd10 + {3'b000, mp_en} + {3'b000, par_en};
   end

   assign q_pop = !busy && !q_empty;
   assign txd   = sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         sh    <= '1;
         nleft <= '0;
         tcnt  <= '0;
      end else if (q_pop) begin
         busy  <= 1'b1;
         sh    <= fr;
         nleft <= nb;
         tcnt  <= '0;
      end else if (busy && tick) begin
         tcnt <= tcnt + 1'b1;
         if (tcnt == 4'd15) begin
            sh    <= {1'b1, sh[11:1]};
            nleft <= nleft - 1'b1;
            if (nleft == 4'd1) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
   import uart_mp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       mp_en,
   input  logic [7:0] node_addr,
   output logic       push,
   output rx_word_t   word
);
   rx_state_t  st;
   logic       s1, s2;
   logic [9:0] fb;
   logic [3:0] idx, nb, tcnt;
   logic       l_mp, l_par, l_odd, accept;
   logic [7:0] dat;
   logic       mk, pb, perr_c, brk_c, ferr_c, pass_c, at_mid;

   always_comb begin
      dat    = fb[7:0];
      mk     = l_mp & fb[8];
      pb     = l_mp ? fb[9] : fb[8];
      brk_c  = (fb == '0) && !s2;
      perr_c = l_par && !brk_c && (pb ^ (^dat) ^ mk ^ l_odd);
      ferr_c = !s2 && !brk_c;
      pass_c = !l_mp || brk_c || (mk ? (dat == node_addr) : accept);
      at_mid = tick && (tcnt == 4'd15);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
      end else begin
         s1 <= rxd;
         s2 <= s1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         fb     <= '0;
         idx    <= '0;
         nb     <= '0;
         tcnt   <= '0;
         l_mp   <= 1'b0;
         l_par  <= 1'b0;
         l_odd  <= 1'b0;
         accept <= 1'b0;
         push   <= 1'b0;
         word   <= '0;
      end else begin
         push <= 1'b0;
         if (tick) tcnt <= tcnt + 1'b1;
         unique case (st)
            RX_IDLE: if (!s2) begin
               st    <= RX_START;
               tcnt  <= '0;
               fb    <= '0;
               idx   <= '0;
               l_mp  <= mp_en;
               l_par <= par_en;
               l_odd <= par_odd;
               nb    <= 4'd8 + {3'b000, mp_en} + {3'b000, par_en};
            end
            RX_START: if (tick && tcnt == 4'd7) begin
               tcnt <= '0;
               st   <= s2 ? RX_IDLE : RX_BITS;
            end
            RX_BITS: if (at_mid) begin
               fb[idx] <= s2;
               idx     <= idx + 1'b1;
               if (idx == nb - 4'd1) st <= RX_STOP;
            end
            RX_STOP: if (at_mid) begin
               push <= pass_c;
               word <= '{brk: brk_c, ferr: ferr_c, perr: perr_c, mark: mk,
                         data: dat};
               if (l_mp && mk && !brk_c) accept <= (dat == node_addr);
               st <= s2 ? RX_IDLE : RX_WAITHI;
            end
            RX_WAITHI: if (s2) st <= RX_IDLE;
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_mp.sv
module uart_mp
   import uart_mp_pkg::*;
#(
   parameter int CLK_DIV  = 4,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_par_en,
   input  logic       cfg_par_odd,
   input  logic       cfg_mp_en,
   input  logic [7:0] cfg_node_addr,
   input  logic [7:0] tx_data,
   input  logic       tx_mark,
   input  logic       tx_valid,
   output logic       tx_ready,
   output logic       txd,
   input  logic       rxd,
   output logic [7:0] rx_data,
   output logic       rx_mark,
   output logic       rx_perr,
   output logic       rx_ferr,
   output logic       rx_brk,
   output logic       rx_valid,
   input  logic       rx_ready,
   output logic       rx_ovf
);
   localparam int TXW = $bits(tx_word_t);
   localparam int RXW = $bits(rx_word_t);

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("uart_mp: CLK_DIV must be at least 1");
      end
   endgenerate

   logic     tick, txq_full, txq_empty, txq_pop, rx_push, rxq_full, rxq_empty;
   tx_word_t txq_in, txq_out;
   rx_word_t rx_word, rxq_out;

   assign txq_in = '{mark: tx_mark, data: tx_data};

   uart_mp_tick #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   uart_mp_fifo #(.WIDTH(TXW), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_valid), .din(txq_in),
      .full(txq_full), .pop(txq_pop), .dout(txq_out), .empty(txq_empty));

   uart_mp_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .par_en(cfg_par_en),
      .par_odd(cfg_par_odd), .mp_en(cfg_mp_en), .q_empty(txq_empty),
      .q_word(txq_out), .q_pop(txq_pop), .txd(txd));

   uart_mp_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_en(cfg_par_en),
      .par_odd(cfg_par_odd), .mp_en(cfg_mp_en), .node_addr(cfg_node_addr),
      .push(rx_push), .word(rx_word));

   uart_mp_fifo #(.WIDTH(RXW), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
      .full(rxq_full), .pop(rx_ready), .dout(rxq_out), .empty(rxq_empty));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  rx_ovf <= 1'b0;
      else if (rx_push && rxq_full) rx_ovf <= 1'b1;
   end

   assign tx_ready = !txq_full;
   assign rx_valid = !rxq_empty;
   assign rx_data  = rxq_out.data;
   assign rx_mark  = rxq_out.mark;
   assign rx_perr  = rxq_out.perr;
   assign rx_ferr  = rxq_out.ferr;
   assign rx_brk   = rxq_out.brk;
endmodule

// File: rtl/uart_mp_chk.sv
module uart_mp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       txd,
   input logic [7:0] rx_data,
   input logic       rx_mark,
   input logic       rx_perr,
   input logic       rx_ferr,
   input logic       rx_brk,
   input logic       rx_valid,
   input logic       rx_ready,
   input logic       rx_ovf
);
   // R2: a start bit lasts more than one clock
   a_r2_start_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txd) |=> !txd);

   // R10: head word holds while not popped
   a_r10_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready |=> rx_valid &&
         $stable({rx_data, rx_mark, rx_perr, rx_ferr, rx_brk}));

   // R9: overflow stays set
   a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovf |=> rx_ovf);

   // R7: a break entry carries no other flag and zero data
   a_r7_brk_clean: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_brk |-> rx_data == 8'h00 && !rx_perr && !rx_ferr);

   // R6: a framing error is never also a break
   a_r6_ferr_not_brk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_ferr |-> !rx_brk);
endmodule

bind uart_mp uart_mp_chk u_chk (
   .clk(clk), .rst_n(rst_n), .txd(txd), .rx_data(rx_data), .rx_mark(rx_mark),
   .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_valid(rx_valid),
   .rx_ready(rx_ready), .rx_ovf(rx_ovf));

// File: tb/tb_uart_mp.sv
module tb_uart_mp;
   localparam int CDIV = 2;
   localparam int BIT  = 16 * CDIV;
   localparam int DEP  = 8;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       cfg_par_en = 0, cfg_par_odd = 0, cfg_mp_en = 0;
   logic [7:0] cfg_node_addr = 8'h3C;
   logic [7:0] tx_data = 0;
   logic       tx_mark = 0, tx_valid = 0, rx_ready = 0;
   logic       loop = 0, rxd_drv = 1;
   logic       txd, rxd, tx_ready, rx_mark, rx_perr, rx_ferr, rx_brk;
   logic       rx_valid, rx_ovf;
   logic [7:0] rx_data;
   int         total = 0, bad = 0;

   assign rxd = loop ? txd : rxd_drv;

   always #2 clk = ~clk;

   uart_mp #(.CLK_DIV(CDIV), .TX_DEPTH(DEP), .RX_DEPTH(DEP)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en),
      .cfg_par_odd(cfg_par_odd), .cfg_mp_en(cfg_mp_en),
      .cfg_node_addr(cfg_node_addr), .tx_data(tx_data), .tx_mark(tx_mark),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
      .rx_data(rx_data), .rx_mark(rx_mark), .rx_perr(rx_perr),
      .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .rx_ovf(rx_ovf));

   task automatic chk(input string req, input logic [31:0] act, exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int nbits(input logic mp, pe);
      return 10 + int'(mp) + int'(pe);
   endfunction

   // expected serial frame, bit 0 first on the line
   function automatic logic [11:0] mkframe(input logic [7:0] d, input logic m,
         input logic mp, pe, po, flip_par, stp);
      logic [11:0] f;
      logic        p;
      int          k;
      f = '1;
      f[0] = 1'b0;
      f[8:1] = d;
      k = 9;
      p = (^d) ^ (mp & m) ^ po ^ flip_par;
      if (mp) begin f[k] = m; k++; end
      if (pe) begin f[k] = p; k++; end
      f[k] = stp;
      return f;
   endfunction

   task automatic send_rx(input logic [11:0] f, input int n);
      for (int i = 0; i < n; i++) begin
         rxd_drv = f[i];
         repeat (BIT) @(negedge clk);
      end
      rxd_drv = 1'b1;
      repeat (BIT) @(negedge clk);
   endtask

   task automatic push_tx(input logic [7:0] d, input logic m);
      @(negedge clk);
      tx_data = d; tx_mark = m; tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic capture_tx(input int n, output logic [11:0] got);
      got = '1;
      while (txd) @(negedge clk);
      repeat (BIT / 2) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         got[i] = txd;
         repeat (BIT) @(negedge clk);
      end
   endtask

   // expected word: {brk, ferr, perr, mark, data}
   task automatic read_rx(input string req, input logic [11:0] exp);
      int w = 0;
      @(negedge clk);
      while (!rx_valid && w < 4000) begin @(negedge clk); w++; end
      chk(req, {20'h0, rx_brk, rx_ferr, rx_perr, rx_mark, rx_data},
          {20'h0, exp});
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [11:0] got;
      int          cnt;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 txd", txd, 1); chk("R1 tx_ready", tx_ready, 1);
      chk("R1 rx_valid", rx_valid, 0); chk("R1 rx_ovf", rx_ovf, 0);

      // R2 directed transmit frames
      fork push_tx(8'hA5, 1'b1); capture_tx(10, got); join
      chk("R2 plain", got[9:0], mkframe(8'hA5, 1, 0, 0, 0, 0, 1) & 12'h3FF);
      repeat (BIT) @(negedge clk);
      cfg_mp_en = 1; cfg_par_en = 1;
      fork push_tx(8'h34, 1'b1); capture_tx(12, got); join
      chk("R2 mark+even", got, mkframe(8'h34, 1, 1, 1, 0, 0, 1));
      repeat (BIT) @(negedge clk);
      cfg_mp_en = 0; cfg_par_odd = 1;
      fork push_tx(8'h07, 1'b0); capture_tx(11, got); join
      chk("R2 odd", got[10:0], mkframe(8'h07, 0, 0, 1, 1, 0, 1) & 12'h7FF);
      repeat (2 * BIT) @(negedge clk);
      cfg_par_en = 0; cfg_par_odd = 0;

      // R3 transmit store depth
      cnt = 0;
      @(negedge clk);
      tx_valid = 1'b1;
      for (int i = 0; i < 20; i++) begin
         tx_data = 8'(i);
         if (tx_ready) begin cnt++; @(negedge clk); end
      end
      tx_valid = 1'b0;
      chk("R3 accepted", cnt, DEP + 1);
      repeat ((DEP + 2) * 11 * BIT) @(negedge clk);
      chk("R3 drained ready", tx_ready, 1);

      // R4 plain reception
      send_rx(mkframe(8'hC3, 0, 0, 0, 0, 0, 1), 10);
      read_rx("R4 plain", {4'b0000, 8'hC3});
      // R5 parity
      cfg_par_en = 1;
      send_rx(mkframe(8'h03, 0, 0, 1, 0, 0, 1), 11);
      read_rx("R5 even ok", {4'b0000, 8'h03});
      send_rx(mkframe(8'h03, 0, 0, 1, 0, 1, 1), 11);
      read_rx("R5 even bad", {4'b0010, 8'h03});
      cfg_par_odd = 1;
      send_rx(mkframe(8'h5B, 0, 0, 1, 1, 0, 1), 11);
      read_rx("R5 odd ok", {4'b0000, 8'h5B});
      cfg_par_en = 0; cfg_par_odd = 0;
      // R6 framing error
      send_rx(mkframe(8'h81, 0, 0, 0, 0, 0, 0), 10);
      read_rx("R6 ferr", {4'b0100, 8'h81});
      // R7 break
      rxd_drv = 1'b0;
      repeat (10 * BIT + 300) @(negedge clk);
      read_rx("R7 break", {4'b1000, 8'h00});
      repeat (BIT) @(negedge clk);
      chk("R7 single entry", rx_valid, 0);
      rxd_drv = 1'b1;
      repeat (BIT) @(negedge clk);
      send_rx(mkframe(8'h5A, 0, 0, 0, 0, 0, 1), 10);
      read_rx("R7 recover", {4'b0000, 8'h5A});

      // R8 address filtering
      cfg_mp_en = 1;
      send_rx(mkframe(8'h12, 0, 1, 0, 0, 0, 1), 11);
      send_rx(mkframe(8'h11, 1, 1, 0, 0, 0, 1), 11);
      send_rx(mkframe(8'h3C, 1, 1, 0, 0, 0, 1), 11);
      send_rx(mkframe(8'h55, 0, 1, 0, 0, 0, 1), 11);
      send_rx(mkframe(8'h11, 1, 1, 0, 0, 0, 1), 11);
      send_rx(mkframe(8'h66, 0, 1, 0, 0, 0, 1), 11);
      read_rx("R8 own addr", {4'b0001, 8'h3C});
      read_rx("R8 data kept", {4'b0000, 8'h55});
      chk("R8 others dropped", rx_valid, 0);
      cfg_mp_en = 0;

      // R9/R10 overflow and order
      for (int i = 0; i <= DEP; i++)
         send_rx(mkframe(8'(8'h20 + i), 0, 0, 0, 0, 0, 1), 10);
      chk("R9 ovf", rx_ovf, 1);
      for (int i = 0; i < DEP; i++)
         read_rx("R10 order", {4'b0000, 8'(8'h20 + i)});
      chk("R9 ninth dropped", rx_valid, 0);

      // R2/R4 random loopback
      loop = 1;
      for (int i = 0; i < 16; i++) begin
         logic [7:0] d;
         logic       m;
         d = 8'($urandom);
         m = 1'($urandom);
         cfg_par_en  = 1'($urandom);
         cfg_par_odd = 1'($urandom);
         push_tx(d, m);
         repeat (13 * BIT) @(negedge clk);
         read_rx("R4 loopback", {4'b0000, d});
      end
      loop = 0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule